// File: doc/BRIEF.md
# Purse Value Arithmetic Unit

This unit does the arithmetic for a stored-value purse held in 16-byte memory blocks. A purse block holds a signed 32-bit amount three times, once of them inverted, and an 8-bit tag four times, alternating plain and inverted. The tag is never interpreted; it is only carried along. A calculation command (increment, decrement or restore) takes one source block from the memory side and checks every redundant copy. When the block is sound, the result goes into an internal holding register. No write takes place. A separate transfer command then commits the holding register to a destination block, re-encoded in the same redundant layout.

The controller is a four-state machine. `ST_IDLE` accepts a command. A calculation command moves it to `ST_FETCH` and a transfer command moves it to `ST_XFER`. `ST_FETCH` waits for the source block and moves to `ST_EXEC` when the block arrives. `ST_EXEC` reports the calculation outcome and returns to `ST_IDLE`. `ST_XFER` performs or refuses the write and returns to `ST_IDLE`. Each of `ST_EXEC` and `ST_XFER` lasts exactly one cycle.

Top module: `purse_value_unit`

## Requirements
- R1: A block is well formed only when all of these hold: bits [31:0] hold the value V, bits [63:32] equal ~V, bits [95:64] equal V, bits [103:96] hold the tag T, bits [111:104] equal ~T, bits [119:112] equal T, and bits [127:120] equal ~T.
- R2: A calculation on a malformed block pulses `err` for one cycle and does not pulse `done`. The holding register, its valid state and the carried tag all stay unchanged.
- R3: Increment (`cmd_op`=2'b00) places V + `cmd_operand` in the holding register and marks it valid. Both numbers are signed 32-bit. `blk_out_we` stays low.
- R4: Decrement (`cmd_op`=2'b01) places V - `cmd_operand` in the holding register and marks it valid. Both numbers are signed 32-bit. `blk_out_we` stays low.
- R5: Restore (`cmd_op`=2'b10) copies V into the holding register unchanged and ignores `cmd_operand`.
- R6: When an increment or decrement overflows the signed 32-bit range, the unit pulses `err` and leaves the holding register invalid.
- R7: Transfer (`cmd_op`=2'b11) with a valid holding register asserts `blk_out_we` and `done` for one cycle. `blk_out_data` carries the held value and the tag of the last accepted source block, in the R1 layout. The holding register is invalid afterwards.
- R8: Transfer with an invalid holding register pulses `err` and does not assert `blk_out_we`.
- R9: After reset, `busy`, `done`, `err` and `blk_out_we` are low and the holding register is invalid.
- R10: A command is accepted only when `busy` is low. `blk_in_valid` is acted on only while a block is awaited. The calculation outcome appears in the cycle after the block is accepted, and the transfer outcome appears in the cycle after the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd_op | input | 2 | 00 increment, 01 decrement, 10 restore, 11 transfer |
| cmd_operand | input | 32 | Signed amount for increment and decrement |
| blk_in_valid | input | 1 | Source block present on `blk_in_data` |
| blk_in_data | input | 128 | Source block read from memory |
| busy | output | 1 | A command is in progress |
| blk_out_we | output | 1 | Write strobe for the destination block |
| blk_out_data | output | 128 | Encoded destination block |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle refusal pulse |

## Verification
The hardest case to reach from the ports is a format error that arrives while the holding register already holds a valid result. Showing that the refusal left the register alone takes two steps. The stimulus first loads a known value by restore, then sends a corrupted block carrying a different tag, then issues a transfer. The written block must still show the first value and first tag. The same chaining is used after an overflow: the transfer that follows must be refused.

// File: rtl/purse_pkg.sv
package purse_pkg;
    typedef enum logic [1:0] {
        OP_INC     = 2'b00,
        OP_DEC     = 2'b01,
        OP_RESTORE = 2'b10,
        OP_XFER    = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_XFER
    } state_e;
endpackage

// File: rtl/vblk_checker.sv
module vblk_checker #(
    parameter int VAL_W  = 32,
    parameter int ADDR_W = 8,
    localparam int SLOTS = 4,
    localparam int BLK_W = 3 * VAL_W + SLOTS * ADDR_W
) (
    input  logic [BLK_W-1:0]  blk,
    output logic [VAL_W-1:0]  value,
    output logic [ADDR_W-1:0] tag,
    output logic              fmt_ok
);
    localparam int TAG_BASE = 3 * VAL_W;

    logic [SLOTS-1:0] slot_ok;
    logic             val_ok;

    assign value  = blk[VAL_W-1:0];
    assign tag    = blk[TAG_BASE +: ADDR_W];
    assign val_ok = (blk[VAL_W +: VAL_W] == ~value) &&
                    (blk[2*VAL_W +: VAL_W] == value);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k % 2 == 0) begin : g_plain
            assign slot_ok[k] = (blk[TAG_BASE + k*ADDR_W +: ADDR_W] == tag);
        end else begin : g_inv
            assign slot_ok[k] = (blk[TAG_BASE + k*ADDR_W +: ADDR_W] == ~tag);
        end
    end

    // R1: every redundant copy must agree
    assign fmt_ok = val_ok && (&slot_ok);
endmodule

// File: rtl/vblk_encoder.sv
module vblk_encoder #(
    parameter int VAL_W  = 32,
    parameter int ADDR_W = 8,
    localparam int SLOTS = 4,
    localparam int BLK_W = 3 * VAL_W + SLOTS * ADDR_W
) (
    input  logic [VAL_W-1:0]  value,
    input  logic [ADDR_W-1:0] tag,
    output logic [BLK_W-1:0]  blk
);
    localparam int TAG_BASE = 3 * VAL_W;

    assign blk[VAL_W-1:0]          = value;
    assign blk[VAL_W +: VAL_W]     = ~value;
    assign blk[2*VAL_W +: VAL_W]   = value;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k % 2 == 0) begin : g_plain
            assign blk[TAG_BASE + k*ADDR_W +: ADDR_W] = tag;
        end else begin : g_inv
            assign blk[TAG_BASE + k*ADDR_W +: ADDR_W] = ~tag;
        end
    end
endmodule

// File: rtl/purse_value_unit.sv
module purse_value_unit #(
    parameter int VAL_W  = 32,
    parameter int ADDR_W = 8,
    localparam int BLK_W = 3 * VAL_W + 4 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [VAL_W-1:0]  cmd_operand,
    input  logic              blk_in_valid,
    input  logic [BLK_W-1:0]  blk_in_data,
    output logic              busy,
    output logic              blk_out_we,
    output logic [BLK_W-1:0]  blk_out_data,
    output logic              done,
    output logic              err
);
    import purse_pkg::*;

    state_e             state_q, state_d;
    op_e                op_q;
    logic [VAL_W-1:0]   opnd_q;
    logic [BLK_W-1:0]   blk_q;
    logic [VAL_W-1:0]   buf_q;
    logic [ADDR_W-1:0]  tag_q;
    logic               buf_vld_q;

    logic [VAL_W-1:0]   src_val;
    logic [ADDR_W-1:0]  src_tag;
    logic               src_ok;
    logic [VAL_W:0]     sum_ext;
    logic               ovf;
    logic [VAL_W-1:0]   calc_res;
    logic               calc_ok;

    vblk_checker #(.VAL_W(VAL_W), .ADDR_W(ADDR_W)) u_srcchk (
        .blk(blk_q), .value(src_val), .tag(src_tag), .fmt_ok(src_ok)
    );

    vblk_encoder #(.VAL_W(VAL_W), .ADDR_W(ADDR_W)) u_enc (
        .value(buf_q), .tag(tag_q), .blk(blk_out_data)
    );

    // signed arithmetic with one guard bit
    always_comb begin
        if (op_q == OP_DEC)
            sum_ext = {src_val[VAL_W-1], src_val} - {opnd_q[VAL_W-1], opnd_q};
        else
            sum_ext = {src_val[VAL_W-1], src_val} + {opnd_q[VAL_W-1], opnd_q};
        ovf      = (op_q != OP_RESTORE) && (sum_ext[VAL_W] != sum_ext[VAL_W-1]);
        calc_res = (op_q == OP_RESTORE) ? src_val : sum_ext[VAL_W-1:0];
        calc_ok  = src_ok && !ovf;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid)
                    state_d = (op_e'(cmd_op) == OP_XFER) ? ST_XFER : ST_FETCH;
            end
            ST_FETCH: if (blk_in_valid) state_d = ST_EXEC;
            ST_EXEC:  state_d = ST_IDLE;
            ST_XFER:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_INC;
            opnd_q    <= '0;
            blk_q     <= '0;
            buf_q     <= '0;
            tag_q     <= '0;
            buf_vld_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && cmd_valid) begin
                op_q   <= op_e'(cmd_op);
                opnd_q <= cmd_operand;
            end
            if (state_q == ST_FETCH && blk_in_valid)
                blk_q <= blk_in_data;
            if (state_q == ST_EXEC && src_ok) begin
                // R6: overflow leaves the holding register invalid
                buf_vld_q <= !ovf;
                buf_q     <= calc_res;
                tag_q     <= src_tag;
            end
            if (state_q == ST_XFER)
                buf_vld_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = 1'b0;
        err        = 1'b0;
        blk_out_we = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FETCH: ;
            ST_EXEC: begin
                done = calc_ok;
                err  = !calc_ok;
            end
            ST_XFER: begin
                blk_out_we = buf_vld_q;
                done       = buf_vld_q;
                err        = !buf_vld_q;
            end
        endcase
    end

    // ---------------- assertions ----------------
    logic [VAL_W-1:0]  chk_val;
    logic [ADDR_W-1:0] chk_tag;
    logic              chk_ok;

    vblk_checker #(.VAL_W(VAL_W), .ADDR_W(ADDR_W)) u_outchk (
        .blk(blk_out_data), .value(chk_val), .tag(chk_tag), .fmt_ok(chk_ok)
    );

    assert_out_format_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_out_we |-> (chk_ok && chk_val == buf_q && chk_tag == tag_q));

    assert_status_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    assert_xfer_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_out_we |=> !blk_out_we);

    assert_bad_block_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && !src_ok) |=> ($stable(buf_q) && $stable(tag_q)));

    assert_cmd_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> busy);

    assert_no_write_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !blk_out_we);
endmodule

// File: tb/purse_value_unit_bench.sv
module purse_value_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'b00;
    logic [31:0]  cmd_operand = '0;
    logic         blk_in_valid = 1'b0;
    logic [127:0] blk_in_data = '0;
    logic         busy, blk_out_we, done, err;
    logic [127:0] blk_out_data;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        bit           e_done;
        bit           e_err;
        bit           e_we;
        logic [127:0] e_data;
        string        tag;
    } exp_t;
    exp_t sb[$];

    // model state
    logic [31:0] m_buf = '0;
    logic [7:0]  m_tag = '0;
    bit          m_vld = 1'b0;

    always #2.5 clk = ~clk;

    purse_value_unit u_purse_value_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_operand(cmd_operand), .blk_in_valid(blk_in_valid),
        .blk_in_data(blk_in_data), .busy(busy), .blk_out_we(blk_out_we),
        .blk_out_data(blk_out_data), .done(done), .err(err)
    );

    function automatic logic [127:0] mk(input logic [31:0] v, input logic [7:0] a);
        return {~a, a, ~a, a, v, ~v, v};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per observed outcome
    always @(negedge clk) begin
        if (rst_n && (done || err || blk_out_we)) begin
            if (sb.size() == 0) begin
                check("R10", "unexpected outcome", {done, err, blk_out_we}, 3'b000);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "done/err/we", {done, err, blk_out_we},
                      {e.e_done, e.e_err, e.e_we});
                if (e.e_we) check(e.tag, "written block", blk_out_data, e.e_data);
            end
        end
    end

    task automatic calc(input logic [1:0] op, input logic [31:0] opnd,
                        input logic [127:0] blk, input string tag);
        exp_t e;
        logic [31:0] v;
        logic [7:0]  a;
        bit ok;
        longint r;
        v  = blk[31:0];
        a  = blk[103:96];
        ok = (blk[63:32] == ~v) && (blk[95:64] == v) && (blk[111:104] == ~a)
             && (blk[119:112] == a) && (blk[127:120] == ~a);
        e.e_we = 1'b0; e.e_data = '0; e.tag = tag;
        if (!ok) begin
            e.e_done = 1'b0; e.e_err = 1'b1;
        end else begin
            if (op == 2'b00)      r = longint'($signed(v)) + longint'($signed(opnd));
            else if (op == 2'b01) r = longint'($signed(v)) - longint'($signed(opnd));
            else                  r = longint'($signed(v));
            m_tag = a;
            if (r > 64'sd2147483647 || r < -64'sd2147483648) begin
                e.e_done = 1'b0; e.e_err = 1'b1; m_vld = 1'b0;
            end else begin
                e.e_done = 1'b1; e.e_err = 1'b0; m_vld = 1'b1; m_buf = r[31:0];
            end
        end
        sb.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_operand = opnd;
        @(negedge clk);
        cmd_valid = 1'b0; blk_in_valid = 1'b1; blk_in_data = blk;
        @(negedge clk);
        blk_in_valid = 1'b0; blk_in_data = '0;
        @(negedge clk);
    endtask

    task automatic xfer(input string tag);
        exp_t e;
        e.tag = tag;
        e.e_done = m_vld; e.e_err = !m_vld; e.e_we = m_vld;
        e.e_data = mk(m_buf, m_tag);
        m_vld = 1'b0;
        sb.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_operand = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "reset outputs", {busy, done, err, blk_out_we}, 4'b0000);

        xfer("R8");                                      // empty buffer
        xfer("R9");                                      // still empty after reset
        calc(2'b10, 32'hDEAD_BEEF, mk(32'd100, 8'h5A), "R5");
        xfer("R7");
        xfer("R8");                                      // second transfer refused
        calc(2'b00, 32'd23, mk(32'd100, 8'h3C), "R3");
        xfer("R3");
        calc(2'b01, 32'd10, mk(-32'sd5, 8'hA1), "R4");
        xfer("R4");
        calc(2'b00, -32'sd50, mk(32'd20, 8'h07), "R3");
        xfer("R3");

        // R2: refusal keeps an already valid buffer
        calc(2'b10, 32'd0, mk(32'd7, 8'h11), "R5");
        calc(2'b00, 32'd1, mk(32'd9, 8'h22) ^ 128'h1 << 40, "R1");
        xfer("R2");
        calc(2'b10, 32'd0, mk(32'd9, 8'h33) ^ (128'h1 << 110), "R1");
        xfer("R2");
        calc(2'b10, 32'd0, mk(32'd9, 8'h33) ^ (128'h1 << 70), "R1");

        // R6: overflow in both directions
        calc(2'b00, 32'd1, mk(32'h7FFF_FFFF, 8'h44), "R6");
        xfer("R6");
        calc(2'b01, 32'd1, mk(32'h8000_0000, 8'h45), "R6");
        xfer("R6");
        calc(2'b01, 32'h8000_0000, mk(32'd0, 8'h46), "R6");
        calc(2'b00, 32'h7FFF_FFFF, mk(32'h8000_0000, 8'h47), "R3");
        xfer("R3");

        // R10: command held while busy, stray block while idle
        begin
            exp_t e;
            e.tag = "R10"; e.e_done = 1'b1; e.e_err = 1'b0; e.e_we = 1'b0; e.e_data = '0;
            sb.push_back(e);
            m_buf = 32'd5; m_tag = 8'h66; m_vld = 1'b1;
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_operand = '0;
        @(negedge clk);
        cmd_op = 2'b11;
        check("R10", "busy while awaiting block", busy, 1'b1);
        @(negedge clk);
        check("R10", "no outcome before block", {done, err, blk_out_we}, 3'b000);
        cmd_valid = 1'b0; blk_in_valid = 1'b1; blk_in_data = mk(32'd5, 8'h66);
        @(negedge clk);
        blk_in_valid = 1'b0;
        @(negedge clk);
        blk_in_valid = 1'b1; blk_in_data = mk(32'd99, 8'h77);
        @(negedge clk);
        @(negedge clk);
        check("R10", "stray block leaves unit idle", busy, 1'b0);
        blk_in_valid = 1'b0;
        xfer("R10");

        repeat (3) @(negedge clk);
        check("R10", "scoreboard drained", 128'(sb.size()), 128'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule